// File: doc/BRIEF.md
# Strobe-Flagged First-In First-Out Buffer (16 x 4)

This block is a small first-in first-out buffer for 4-bit words with a depth of 16. It has two strobes that are independent of each other. A load strobe writes the word on `din` when it falls. An unload strobe removes the oldest word when it rises. Both strobes may be asynchronous to the system clock. Each passes through its own flip-flop synchronizer, and its edges are detected in the clock domain. The oldest stored word is always present on `dout`, so a consumer reads it before it raises the unload strobe.

Two flags tell the producer and consumer when they may go ahead. `in_rdy` shows that there is room and the load strobe is low. `out_rdy` shows that data is present and the unload strobe is high. A parameter adds an enable input for each flag that can mask it. The active-low `clr_n` empties the buffer. `oe` releases the data bus without changing either flag. The strobes are the only flow control at the block's edge. A producer that toggles the load strobe while `in_rdy` is low loses that word, and a consumer that raises the unload strobe while the buffer is empty gets nothing.

Top module: `strobe_fifo16x4`

## Requirements
- R1: Words leave in the order they were loaded, and each word appears on `dout` with the same bit values it had on `din`. There are at most 16 words in storage.
- R2: A high-to-low change of `load_stb` writes `din` into the buffer. The write takes effect at the third rising clock edge after the change is first sampled. A word written into an empty buffer is on `dout` right after that edge.
- R3: A low-to-high change of `unload_stb` removes the oldest word at the third rising clock edge after the change is first sampled. The next word then appears on `dout`.
- R4: When 16 words are stored, a falling edge of `load_stb` is ignored. The stored contents and the count do not change.
- R5: When the buffer is empty, a rising edge of `unload_stb` is ignored. A later load is still the first word that comes out.
- R6: `in_rdy` is 1 only when fewer than 16 words are stored, the synchronized `load_stb` level is 0, and `in_rdy_en` is 1.
- R7: `out_rdy` is 1 only when at least one word is stored, the synchronized `unload_stb` level is 1, and `out_rdy_en` is 1.
- R8: While `clr_n` is 0, `in_rdy` is 1 and `out_rdy` is 0. When `clr_n` is released the buffer is empty, whatever it held before.
- R9: When `oe` is 0, all four bits of `dout` are high impedance. `oe` does not affect `in_rdy` or `out_rdy`.
- R10: If an accepted load edge and an accepted unload edge act in the same cycle, the word count does not change and the oldest word moves on by one.
- R11: When `in_rdy_en` is 0, `in_rdy` is 0. When `out_rdy_en` is 0, `out_rdy` is 0. The data path does not depend on either enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear: empties the buffer |
| load_stb | input | 1 | Load strobe; its falling edge writes a word |
| unload_stb | input | 1 | Unload strobe; its rising edge removes a word |
| din | input | 4 | Data word to load |
| oe | input | 1 | Data output enable; 0 floats `dout` |
| in_rdy_en | input | 1 | Mask for `in_rdy` (active high) |
| out_rdy_en | input | 1 | Mask for `out_rdy` (active high) |
| in_rdy | output | 1 | Room available and load strobe low |
| out_rdy | output | 1 | Data available and unload strobe high |
| dout | output | 4 | Oldest stored word, tri-stated by `oe` |

## Verification
A load edge and an unload edge can be accepted in the same clock cycle. The two strobes have the same synchronizer latency, so they collide whenever both are changed together. The bench does this on purpose with a full buffer, an empty buffer and a partly filled buffer, and random stimulus also does it often. Each collision is judged against a queue model in the bench. In the model, a load into a full buffer and an unload from an empty buffer are each decided on the count from before the cycle. The count, both flags and the word on `dout` must then agree with the model.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int unsigned SF_DEPTH_DEF = 16;
  localparam int unsigned SF_WIDTH_DEF = 4;
  localparam int unsigned SF_SYNC_DEF  = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_sync_edge.sv
module strobe_sync_edge
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned STAGES = SF_SYNC_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_in,
  output strobe_ev_t ev
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], strobe_in};
      prev <= sr[STAGES-1];
    end
  end

  always_comb begin
    ev.level = sr[STAGES-1];
    ev.rise  = sr[STAGES-1] & ~prev;
    ev.fall  = ~sr[STAGES-1] & prev;
  end

  // R2: a detected edge lasts exactly one cycle
  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ev.fall |=> !ev.fall);
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rise |=> !ev.rise);
endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] cnt;
  logic          rd_ok;

  assign full  = (cnt == CNT_FULL);
  assign empty = (cnt == '0);
  assign wr_ok = wr_req && !full;
  assign rd_ok = rd_req && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);
  a_r4_full_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> (full && $stable(wr_ptr)));
  a_r5_empty_blocks_unload: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> (empty && $stable(rd_ptr)));
  a_r10_simul_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> $stable(cnt));
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && empty) |=> !empty);
endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(i))) mem[i] <= wdata;
    end
  end

  assign head = mem[raddr];
endmodule

// File: rtl/strobe_fifo16x4.sv
module strobe_fifo16x4
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = SF_DEPTH_DEF,
  parameter int unsigned WIDTH       = SF_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = SF_SYNC_DEF,
  parameter bit          HAS_FLAG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_stb,
  input  logic             unload_stb,
  input  logic [WIDTH-1:0] din,
  input  logic             oe,
  input  logic             in_rdy_en,
  input  logic             out_rdy_en,
  output logic             in_rdy,
  output logic             out_rdy,
  output wire  [WIDTH-1:0] dout
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  strobe_ev_t       ld_ev, ul_ev;
  logic             wr_ok, full, empty;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [WIDTH-1:0] head;
  logic             ir_gate, or_gate;

  strobe_sync_edge #(.STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(clk), .rst_n(clr_n), .strobe_in(load_stb), .ev(ld_ev));

  strobe_sync_edge #(.STAGES(SYNC_STAGES)) u_ul_sync (
    .clk(clk), .rst_n(clr_n), .strobe_in(unload_stb), .ev(ul_ev));

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(clr_n), .wr_req(ld_ev.fall), .rd_req(ul_ev.rise),
    .wr_ok(wr_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty));

  strobe_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(din), .raddr(rd_ptr), .head(head));

  if (HAS_FLAG_EN) begin : g_flag_en
    assign ir_gate = in_rdy_en;
    assign or_gate = out_rdy_en;
  end else begin : g_no_flag_en
    assign ir_gate = 1'b1;
    assign or_gate = 1'b1;
  end

  always_comb begin
    if (!clr_n) begin
      in_rdy  = 1'b1;
      out_rdy = 1'b0;
    end else begin
      in_rdy  = !full && !ld_ev.level && ir_gate;
      out_rdy = !empty && ul_ev.level && or_gate;
    end
  end

  assign dout = oe ? head : {WIDTH{1'bz}};

  a_r6_in_rdy_needs_room: assert property (@(posedge clk) disable iff (!clr_n)
    in_rdy |-> !u_ctrl.full);
  a_r7_out_rdy_needs_data: assert property (@(posedge clk) disable iff (!clr_n)
    out_rdy |-> !u_ctrl.empty);
endmodule

// File: tb/strobe_fifo16x4_bench.sv
module strobe_fifo16x4_bench;
  logic       clk = 1'b0;
  logic       clr_n, load_stb, unload_stb, oe, in_rdy_en, out_rdy_en;
  logic [3:0] din;
  logic       in_rdy, out_rdy;
  wire  [3:0] dout_w;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0] q[$];
  logic       prev_ld, prev_ul;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g_pu
    pullup (dout_w[i]);
  end

  strobe_fifo16x4 u_strobe_fifo16x4 (
    .clk(clk), .clr_n(clr_n), .load_stb(load_stb), .unload_stb(unload_stb),
    .din(din), .oe(oe), .in_rdy_en(in_rdy_en), .out_rdy_en(out_rdy_en),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout_w));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_in_rdy();
    return (q.size() < 16) && !load_stb && in_rdy_en;
  endfunction

  function automatic bit exp_out_rdy();
    return (q.size() > 0) && unload_stb && out_rdy_en;
  endfunction

  task automatic check_outputs(input string req);
    chk(in_rdy == exp_in_rdy(), {req, "/R6 in_rdy"}, in_rdy, exp_in_rdy());
    chk(out_rdy == exp_out_rdy(), {req, "/R7 out_rdy"}, out_rdy, exp_out_rdy());
    if (!oe) chk(dout_w == 4'hF, {req, "/R9 hiz"}, dout_w, 4'hF);
    else if (q.size() > 0) chk(dout_w == q[0], {req, "/R1 head"}, dout_w, q[0]);
  endtask

  // apply one strobe pattern, let it settle, update the model, check
  task automatic step(input logic ld, input logic ul, input logic [3:0] d, input string req);
    bit was_full, was_empty;
    @(negedge clk);
    load_stb = ld; unload_stb = ul; din = d;
    repeat (4) @(negedge clk);
    was_full  = (q.size() == 16);
    was_empty = (q.size() == 0);
    if (prev_ld && !ld && !was_full) q.push_back(d);
    if (!prev_ul && ul && !was_empty) void'(q.pop_front());
    prev_ld = ld; prev_ul = ul;
    check_outputs(req);
  endtask

  task automatic do_clear();
    @(negedge clk);
    load_stb = 1'b0; unload_stb = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    chk(in_rdy == 1'b1, "R8 in_rdy during clear", in_rdy, 1);
    chk(out_rdy == 1'b0, "R8 out_rdy during clear", out_rdy, 0);
    clr_n = 1'b1;
    q.delete(); prev_ld = 1'b0; prev_ul = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clr_n = 1'b0; load_stb = 1'b0; unload_stb = 1'b0; din = 4'h0;
    oe = 1'b1; in_rdy_en = 1'b1; out_rdy_en = 1'b1;
    prev_ld = 1'b0; prev_ul = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_rdy == 1'b1, "R8 reset in_rdy", in_rdy, 1);
    chk(out_rdy == 1'b0, "R8 reset out_rdy", out_rdy, 0);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    check_outputs("R8 after release");

    // R2 latency: unload held high (ignored when empty, R5), then load falls
    step(1'b1, 1'b1, 4'h3, "R5 unload rise on empty");
    @(negedge clk);
    din = 4'hA; load_stb = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(out_rdy == 1'b0, "R2 not yet written", out_rdy, 0);
    @(posedge clk); #1;
    chk(out_rdy == 1'b1, "R2 written at third edge", out_rdy, 1);
    chk(dout_w == 4'hA, "R2 word visible", dout_w, 4'hA);
    repeat (2) @(negedge clk);
    q.push_back(4'hA); prev_ld = 1'b0;
    step(1'b0, 1'b0, 4'h0, "R3 unload low");
    step(1'b0, 1'b1, 4'h0, "R3 unload rise");
    chk(q.size() == 0 && out_rdy == 1'b0, "R3 drained", out_rdy, 0);

    // fill to 16 (R4)
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 4'h0, "R4 fill hi");
      step(1'b0, 1'b0, 4'(i ^ 5), "R4 fill lo");
    end
    chk(in_rdy == 1'b0, "R4 full in_rdy low", in_rdy, 0);
    step(1'b1, 1'b0, 4'h0, "R4 extra hi");
    step(1'b0, 1'b0, 4'hE, "R4 extra load ignored");
    // R10 at full: load ignored, unload accepted
    step(1'b1, 1'b0, 4'h0, "R10 prep");
    step(1'b0, 1'b1, 4'h9, "R10 both at full");
    // R9 output enable
    oe = 1'b0;
    step(1'b1, 1'b1, 4'h0, "R9 oe low");
    oe = 1'b1;
    // R11 enables
    in_rdy_en = 1'b0; out_rdy_en = 1'b0;
    step(1'b1, 1'b0, 4'h0, "R11 masked");
    step(1'b0, 1'b1, 4'h6, "R11 masked both");
    chk(out_rdy == 1'b0, "R11 out_rdy masked", out_rdy, 0);
    in_rdy_en = 1'b1; out_rdy_en = 1'b1;
    // drain in order (R1)
    while (q.size() > 0) begin
      step(1'b1, 1'b0, 4'h0, "R1 drain lo");
      step(1'b1, 1'b1, 4'h0, "R1 drain hi");
    end
    // R10 at empty: load accepted, unload ignored
    step(1'b1, 1'b0, 4'h0, "R10 empty prep");
    step(1'b0, 1'b1, 4'h7, "R10 both at empty");
    chk(dout_w == 4'h7 && out_rdy, "R10 empty collision", dout_w, 4'h7);

    // R8 clear with data
    step(1'b1, 1'b0, 4'h0, "R8 prep");
    step(1'b0, 1'b0, 4'h2, "R8 prep load");
    do_clear();
    step(1'b0, 1'b1, 4'h0, "R8 empty after clear");
    chk(out_rdy == 1'b0, "R8 cleared empty", out_rdy, 0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic rl, ru;
      rl = 1'($urandom);
      ru = 1'($urandom);
      oe = ($urandom % 10) != 0;
      in_rdy_en = ($urandom % 8) != 0;
      out_rdy_en = ($urandom % 8) != 0;
      step(rl, ru, 4'($urandom), "R10 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule